// File: doc/BRIEF.md
# Cell Receive Deframer

This block sits behind a link receiver. It accepts a stream of 53-byte cells, one byte per cycle, on a valid strobe. A start flag marks the first header byte. The fifth byte of each cell is the header check byte. The block recomputes that byte over the four header bytes and then drops it, so it is never stored. Cells that pass the check are written into a buffer sized for two cells.

A cell becomes readable only once it is complete and checked. The reader then sees a FIFO-like port: an active-low read strobe and an active-low not-empty flag. Each read yields a 9-bit entry made of a cell-start bit and a data byte. Every cell is delivered as one marker entry (cell-start bit set, data zero) followed by its 52 stored bytes. This is the same entry stream a transmit port produces, so two such ports can be cross-connected.

The DEPTH parameter must be a power of two and at least 104 (two cells).

Top module: `cell_rx_deframer`

## Requirements
- R1: After reset, `empty_n` is 0, `hec_err` is 0, `ovf` is 0 and `rd_data` is 9'h000.
- R2: A read happens on the first clock edge at which `rd_n` is sampled low after having been sampled high. At that edge `rd_data` takes the next entry. Holding `rd_n` low for more edges delivers no further entries.
- R3: The first entry of every delivered cell is 9'h100, meaning bit 8 (cell start) is 1 and bits 7:0 are 0.
- R4: After the marker come exactly 52 entries with bit 8 clear, in this order:
  - the four header bytes, in arrival order;
  - the 48 payload bytes that followed the check byte, in arrival order.
  The check byte itself never appears.
- R5: `empty_n` rises in the cycle after the edge that accepts the 53rd byte of a good cell. It falls in the cycle after the edge that reads the last stored byte.
- R6: While a cell is still arriving, it adds nothing to what the reader can see. With an otherwise empty buffer, `empty_n` stays 0 until the cell is complete.
- R7: The expected check byte is a CRC-8 over the four header bytes, XORed with 0x55. The CRC uses polynomial x^8+x^2+x+1, initial value 0, most significant bit first. On a mismatch the cell is discarded and `hec_err` is set and stays set until reset.
- R8: The buffer holds two full cells. If a cell starts when fewer than 52 free byte slots remain, the whole cell is dropped and `ovf` is set and stays set until reset. Cells already stored are unaffected.
- R9: A read while `empty_n` is 0 changes neither `rd_data` nor the read position. The next cell is delivered intact, starting with its marker.
- R10: A byte with `in_sof` high restarts framing and abandons any partial cell. Valid bytes that arrive outside a cell are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming byte is valid this cycle |
| in_sof | input | 1 | Incoming byte is the first header byte of a cell |
| in_byte | input | 8 | Incoming link byte |
| rd_n | input | 1 | Active-low read strobe |
| rd_data | output | 9 | Last entry read: bit 8 cell start, bits 7:0 data |
| empty_n | output | 1 | Low when no entry is available |
| hec_err | output | 1 | Sticky header check failure |
| ovf | output | 1 | Sticky whole-cell drop due to full buffer |

## Verification
Several cells are sent, each with a different header and a different payload ramp (different start values and step sizes). A misplaced header byte, a leaked check byte or an off-by-one in payload ordering would each show up as a distinct data mismatch.

A corrupted check byte tests discard against delivery. A truncated cell followed by a new start tests restart against stitching the two together. Three back-to-back cells with no reads test dropping a whole cell against overwriting a stored one. Reads while empty and a strobe held low for several cycles test the strobe edge rule.

// File: rtl/cell_rx_deframer.sv
module cell_rx_deframer #(
  parameter int DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_byte,
  input  logic       rd_n,
  output logic [8:0] rd_data,
  output logic       empty_n,
  output logic       hec_err,
  output logic       ovf
);
  localparam int AW     = $clog2(DEPTH);
  localparam int CELL_B = 52;
  localparam int LAST_I = 52;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int b = 0; b < 8; b++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  logic [8:0]    mem [DEPTH];
  logic [AW:0]   wr_base, rd_ptr;
  logic [5:0]    idx, phase;
  logic          in_cell, drop, rd_q;
  logic [7:0]    crc;
  logic          wr_en;
  logic [AW-1:0] wr_addr;

  wire [AW:0] used  = wr_base - rd_ptr;
  wire        room  = (DEPTH - int'(used)) >= CELL_B;
  wire        start = in_valid & in_sof;
  wire        cont  = in_valid & ~in_sof & in_cell;
  wire        fire  = rd_q & ~rd_n;

  assign empty_n = (wr_base != rd_ptr);

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = wr_base[AW-1:0];
    if (start) begin
      wr_en = room;
    end else if (cont && !drop && idx != 6'd4) begin
      wr_en   = 1'b1;
      wr_addr = (idx < 6'd4) ? wr_base[AW-1:0] + AW'(idx)
                             : wr_base[AW-1:0] + AW'(idx - 6'd1);
    end
  end

  always_ff @(posedge clk) if (wr_en) mem[wr_addr] <= {1'b0, in_byte};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_base <= '0;
      idx     <= '0;
      in_cell <= 1'b0;
      drop    <= 1'b0;
      crc     <= '0;
      hec_err <= 1'b0;
      ovf     <= 1'b0;
    end else if (start) begin
      in_cell <= 1'b1;
      idx     <= 6'd1;
      drop    <= ~room;
      crc     <= crc_step(8'h00, in_byte);
      if (!room) ovf <= 1'b1;
    end else if (cont) begin
      idx <= idx + 6'd1;
      if (idx < 6'd4) crc <= crc_step(crc, in_byte);
      if (idx == 6'd4 && in_byte != (crc ^ 8'h55)) begin
        drop    <= 1'b1;
        hec_err <= 1'b1;
      end
      if (idx == 6'(LAST_I)) begin
        in_cell <= 1'b0;
        if (!drop) wr_base <= wr_base + (AW+1)'(CELL_B);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= 1'b1;
      rd_ptr  <= '0;
      phase   <= '0;
      rd_data <= '0;
    end else begin
      rd_q <= rd_n;
      if (fire && empty_n) begin
        if (phase == 6'd0) begin
          rd_data <= 9'h100;
          phase   <= 6'd1;
        end else begin
          rd_data <= mem[rd_ptr[AW-1:0]];
          rd_ptr  <= rd_ptr + 1'b1;
          phase   <= (phase == 6'(CELL_B)) ? 6'd0 : phase + 6'd1;
        end
      end
    end
  end
endmodule

// File: rtl/cell_rx_deframer_chk.sv
module cell_rx_deframer_chk #(
  parameter int DEPTH = 128
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rd_n,
  input logic                     rd_q,
  input logic                     empty_n,
  input logic [8:0]               rd_data,
  input logic [5:0]               phase,
  input logic [$clog2(DEPTH):0]   rd_ptr,
  input logic [$clog2(DEPTH):0]   wr_base,
  input logic                     hec_err,
  input logic                     ovf
);
  localparam int AW = $clog2(DEPTH);
  wire fire = rd_q & ~rd_n;

  assert_buffer_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_base - rd_ptr) <= DEPTH);
  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !empty_n |=> $stable(rd_ptr) && $stable(rd_data));
  assert_marker_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && empty_n && phase == 6'd0 |=> rd_data == 9'h100);
  assert_data_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && empty_n && phase != 6'd0 |=> !rd_data[8]);
  assert_whole_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base == $past(wr_base) || wr_base == $past(wr_base) + (AW+1)'(52));
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hec_err |=> hec_err);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
endmodule

bind cell_rx_deframer cell_rx_deframer_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .rd_q(rd_q), .empty_n(empty_n),
  .rd_data(rd_data), .phase(phase), .rd_ptr(rd_ptr), .wr_base(wr_base),
  .hec_err(hec_err), .ovf(ovf));

// File: tb/cell_rx_deframer_tb.sv
module cell_rx_deframer_tb_top;
  localparam int PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, rd_n = 1'b1;
  logic [7:0] in_byte = '0;
  logic [8:0] rd_data;
  logic       empty_n, hec_err, ovf;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  cell_rx_deframer dut_i (.clk, .rst_n, .in_valid, .in_sof, .in_byte, .rd_n,
                          .rd_data, .empty_n, .hec_err, .ovf);

  localparam logic [47:0] VEC [4] = '{
    48'h00000000_00_01, 48'h12345678_10_03,
    48'hFFEEDDCC_80_FF, 48'hA5C3_0F96_7E_25 };

  function automatic logic [7:0] hec_of(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int k = 0; k < 4; k++) begin
      c = c ^ h[31-8*k -: 8];
      for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c ^ 8'h55;
  endfunction

  function automatic logic [8:0] exp_entry(input logic [31:0] h, input logic [7:0] s,
                                           input logic [7:0] st, input int e);
    if (e == 0) return 9'h100;
    if (e < 5) return {1'b0, h[31-8*(e-1) -: 8]};
    return {1'b0, 8'(s + st * 8'(e - 5))};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_cell(input logic [31:0] h, input logic [7:0] s, input logic [7:0] st,
                           input bit bad, input int n, input bit see_empty);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (see_empty && i == 52) chk(!empty_n, "R6 hidden while arriving", 9'(empty_n), 9'd0);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      if (i < 4)       in_byte = h[31-8*i -: 8];
      else if (i == 4) in_byte = hec_of(h) ^ (bad ? 8'hFF : 8'h00);
      else             in_byte = 8'(s + st * 8'(i - 5));
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic read_entry(output logic [8:0] v);
    @(negedge clk);
    rd_n = 1'b0;
    @(negedge clk);
    v    = rd_data;
    rd_n = 1'b1;
  endtask

  task automatic read_cell(input logic [31:0] h, input logic [7:0] s, input logic [7:0] st,
                           input int first, input bit final_cell);
    logic [8:0] v;
    for (int e = first; e < 53; e++) begin
      read_entry(v);
      chk(v === exp_entry(h, s, st, e), e == 0 ? "R3 marker" : "R4 data order", v, exp_entry(h, s, st, e));
      if (e == 51) chk(empty_n, "R5 still readable", 9'(empty_n), 9'd1);
    end
    if (final_cell) chk(!empty_n, "R5 empty after last", 9'(empty_n), 9'd0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [8:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!empty_n && !hec_err && !ovf, "R1 flags", {6'd0, empty_n, hec_err, ovf}, 9'd0);
    chk(rd_data == 9'h000, "R1 data", rd_data, 9'h000);

    // R10: stray bytes outside a cell
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); in_valid = 1'b1; in_byte = 8'(i + 3);
    end
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    chk(!empty_n, "R10 stray bytes ignored", 9'(empty_n), 9'd0);

    // R9: read while empty
    read_entry(v);
    chk(v == 9'h000 && !empty_n, "R9 empty read", v, 9'h000);

    // table walk
    foreach (VEC[k]) begin
      send_cell(VEC[k][47:16], VEC[k][15:8], VEC[k][7:0], 1'b0, 53, 1'b1);
      chk(empty_n, "R5 visible after cell", 9'(empty_n), 9'd1);
      read_cell(VEC[k][47:16], VEC[k][15:8], VEC[k][7:0], 0, 1'b1);
    end

    // R2: held strobe delivers one entry
    send_cell(32'hCAFE0001, 8'h40, 8'h02, 1'b0, 53, 1'b0);
    @(negedge clk); rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(rd_data == 9'h100, "R2 held strobe single entry", rd_data, 9'h100);
    rd_n = 1'b1;
    read_cell(32'hCAFE0001, 8'h40, 8'h02, 1, 1'b1);

    // R7: bad check byte discards, sticky
    send_cell(32'h0BADCE11, 8'h11, 8'h01, 1'b1, 53, 1'b0);
    chk(hec_err && !empty_n, "R7 bad cell dropped", {7'd0, hec_err, empty_n}, 9'h002);
    send_cell(32'h600DCE11, 8'h22, 8'h05, 1'b0, 53, 1'b0);
    chk(hec_err, "R7 error sticky", 9'(hec_err), 9'd1);
    read_cell(32'h600DCE11, 8'h22, 8'h05, 0, 1'b1);

    // R10: restart mid cell
    send_cell(32'hDEAD0000, 8'h99, 8'h09, 1'b0, 20, 1'b0);
    chk(!empty_n, "R10 partial not visible", 9'(empty_n), 9'd0);
    send_cell(32'h01020304, 8'h55, 8'h07, 1'b0, 53, 1'b0);
    read_cell(32'h01020304, 8'h55, 8'h07, 0, 1'b1);
    chk(!ovf, "R8 no overflow yet", 9'(ovf), 9'd0);

    // R8: third cell dropped whole
    send_cell(32'h11111111, 8'h01, 8'h01, 1'b0, 53, 1'b0);
    send_cell(32'h22222222, 8'h02, 8'h02, 1'b0, 53, 1'b0);
    send_cell(32'h33333333, 8'h03, 8'h03, 1'b0, 53, 1'b0);
    chk(ovf, "R8 overflow flagged", 9'(ovf), 9'd1);
    read_cell(32'h11111111, 8'h01, 8'h01, 0, 1'b0);
    read_cell(32'h22222222, 8'h02, 8'h02, 0, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule